// File: doc/BRIEF.md
# Twin byte timer

This block provides two 8-bit up-counters that share one free-running prescaler. Each channel has two compare values (A and B), a counter, a control byte and a clock-selection byte, plus a status byte that software can store and read. A channel counts at one of seven prescaled rates. It raises one-cycle interrupt pulses on compare A, compare B and overflow, and it can clear its counter on a compare A or compare B match.

The pair has two operating modes, decoded from channel 0's clock selection. In MODE_SPLIT the channels run independently. Selecting the chained source on channel 0 moves the pair into MODE_CASCADE, and clearing that source returns it to MODE_SPLIT. In MODE_CASCADE, channel 0 advances on every carry out of channel 1, so the pair acts as one 16-bit counter with channel 0 as the upper byte. The 16-bit value is compared against the paired compare registers, and channel 0's control byte decides clearing and interrupts.

A register port accepts byte and halfword accesses. Reads are combinational and writes take effect on the clock edge.

Top module: `twin_byte_timer`

## Requirements
- R1: After reset, all four compare registers read 0xFF. Counters, control bytes and clock bytes read 0x00. The status byte reads 0x00 on channel 0 and 0x10 on channel 1.
- R2: Register addressing: address bit 0 selects the channel (0 or 1), and address bits [3:1] select the register: 0 control, 1 status, 2 compare A, 3 compare B, 4 counter, 5 clock selection. A byte read returns the value zero-extended to 16 bits. Selections 6 and 7 read 0 and ignore writes. Clock selection bits [7:5] read as zero.
- R3: A halfword access at an even address covers both channels of the register, with channel 0 in bits [15:8] and channel 1 in bits [7:0]. A halfword access at an odd address reads 0 and its write is ignored.
- R4: Reads of the control and status bytes return bits [2:0] as zero.
- R5: Clock selection bits [4:3] = 01 selects the prescaled clock. Bits [2:0] set the period in cycles per count: 001=1, 010=2, 011=8, 100=32, 101=64, 110=1024, 111=8192. Code 000 holds the counter. Source codes 00 and 10, and 11 on channel 1, never advance the counter.
- R6: Each count adds one. Advancing from 0xFF wraps to 0x00 and raises the overflow event.
- R7: When the counter takes a value equal to compare A (or compare B), the compare A (or compare B) event is raised.
- R8: Control bits [4:3] set clearing: 01 loads 0 instead of the matching value on a compare A event, and 10 does the same on a compare B event. Other codes never clear.
- R9: Control bit 7 enables the compare B interrupt, bit 6 the compare A interrupt and bit 5 the overflow interrupt. Each enabled event drives a one-cycle high pulse on its own line, in the cycle after the edge that changed the counter. A disabled event produces no pulse.
- R10: When compare A and compare B both match in the same count, both events are raised and the counter is cleared only once.
- R11: With channel 0 clock bits [4:3] = 11, the pair is one 16-bit counter {ch0, ch1}. It advances at channel 1's rate. Compares use {ch0 A, ch1 A} and {ch0 B, ch1 B}, overflow happens on the wrap from 0xFFFF, and clear mode and interrupt enables come from channel 0. Channel 1's three interrupt lines stay low in this mode.
- R12: A write to a counter takes priority over counting in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current access |
| bus_wide | input | 1 | 1 = halfword access, 0 = byte access |
| bus_addr | input | AW | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| irq_cmp_a | output | 2 | Compare A interrupt pulse, one bit per channel |
| irq_cmp_b | output | 2 | Compare B interrupt pulse, one bit per channel |
| irq_wrap | output | 2 | Overflow interrupt pulse, one bit per channel |

## Verification
The hardest situations to reach from the ports are in MODE_CASCADE: a 16-bit compare match whose target lies just past a low-byte carry, and the 16-bit wrap from 0xFFFF. In both cases a byte-wide compare on channel 1 alone would fire at a different count. The stimulus uses halfword writes to preload the pair a few counts below the boundary. It then runs the divide-by-1 clock for an exact number of edges and checks both the final 16-bit value and the pulse counts on all six lines, so that a stray channel 1 event is caught.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int BYTE_W   = 8;
    localparam int PAIR_W   = 2 * BYTE_W;
    localparam int PRE_W    = 13;
    localparam int NCH      = 2;

    // control byte field positions (only bits [7:3] are stored)
    localparam int CTRL_LSB = 3;
    localparam int IE_B_BIT = 7;
    localparam int IE_A_BIT = 6;
    localparam int IE_O_BIT = 5;
    localparam int CLKC_W   = 5;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'b00,
        SRC_INT   = 2'b01,
        SRC_RSV   = 2'b10,
        SRC_CHAIN = 2'b11
    } src_e;

    typedef enum logic [0:0] {
        MODE_SPLIT   = 1'b0,
        MODE_CASCADE = 1'b1
    } pair_mode_e;

    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_STAT = 3'd1,
        REG_CMPA = 3'd2,
        REG_CMPB = 3'd3,
        REG_CNT  = 3'd4,
        REG_CLKC = 3'd5,
        REG_NA6  = 3'd6,
        REG_NA7  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [BYTE_W-1:0] cmpa;
        logic [BYTE_W-1:0] cmpb;
        logic [BYTE_W-1:0] cnt;
        logic [1:0]        src;
    } chan_view_t;

    // log2 of the divide ratio for a rate code; code 0 is handled as stop
    function automatic int rate_log2(input logic [2:0] code);
        case (code)
            3'd2:    return 1;
            3'd3:    return 3;
            3'd4:    return 5;
            3'd5:    return 6;
            3'd6:    return 10;
            3'd7:    return 13;
            default: return 0;
        endcase
    endfunction

    function automatic logic clear_hit(input logic [1:0] mode_bits,
                                       input logic hit_a, input logic hit_b);
        return (mode_bits == 2'b01 && hit_a) || (mode_bits == 2'b10 && hit_b);
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int CHANNELS = NCH,
    parameter int PW       = PRE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CHANNELS-1:0][2:0] rate,
    output logic [CHANNELS-1:0]      tick
);
    logic [PW-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    for (genvar g = 0; g < CHANNELS; g++) begin : g_tap
        logic [PW-1:0] low_mask;
        always_comb begin
            low_mask = '0;
            for (int b = 0; b < PW; b++) begin
                if (b < rate_log2(rate[g])) low_mask[b] = 1'b1;
            end
        end
        assign tick[g] = (rate[g] != 3'd0) && ((pre_q & low_mask) == low_mask);
    end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
(
    input  chan_view_t [NCH-1:0]             ch,
    input  logic [NCH-1:0][1:0]              clr_mode,
    input  logic [NCH-1:0]                   tick,
    input  logic [NCH-1:0]                   cnt_wr,
    output pair_mode_e                       mode,
    output logic [NCH-1:0]                   adv,
    output logic [NCH-1:0][BYTE_W-1:0]       nxt,
    output logic [NCH-1:0]                   ev_a,
    output logic [NCH-1:0]                   ev_b,
    output logic [NCH-1:0]                   ev_o
);
    logic [NCH-1:0] run;

    always_comb begin
        logic [BYTE_W-1:0] s8;
        logic [PAIR_W-1:0] s16;
        logic              hit_a;
        logic              hit_b;

        s8    = '0;
        s16   = '0;
        hit_a = 1'b0;
        hit_b = 1'b0;
        mode  = (src_e'(ch[0].src) == SRC_CHAIN) ? MODE_CASCADE : MODE_SPLIT;
        for (int i = 0; i < NCH; i++) begin
            run[i] = (src_e'(ch[i].src) == SRC_INT) && tick[i] && !cnt_wr[i];
            nxt[i] = ch[i].cnt;
        end
        adv  = '0;
        ev_a = '0;
        ev_b = '0;
        ev_o = '0;

        unique case (mode)
            MODE_SPLIT: begin
                for (int i = 0; i < NCH; i++) begin
                    if (run[i]) begin
                        s8      = ch[i].cnt + 1'b1;
                        hit_a   = (s8 == ch[i].cmpa);
                        hit_b   = (s8 == ch[i].cmpb);
                        ev_a[i] = hit_a;
                        ev_b[i] = hit_b;
                        ev_o[i] = (ch[i].cnt == '1);
                        adv[i]  = 1'b1;
                        nxt[i]  = clear_hit(clr_mode[i], hit_a, hit_b) ? '0 : s8;
                    end
                end
            end
            MODE_CASCADE: begin
                if (run[1] && !cnt_wr[0]) begin
                    s16     = {ch[0].cnt, ch[1].cnt} + 1'b1;
                    hit_a   = (s16 == {ch[0].cmpa, ch[1].cmpa});
                    hit_b   = (s16 == {ch[0].cmpb, ch[1].cmpb});
                    ev_a[0] = hit_a;
                    ev_b[0] = hit_b;
                    ev_o[0] = ({ch[0].cnt, ch[1].cnt} == '1);
                    adv     = '1;
                    {nxt[0], nxt[1]} = clear_hit(clr_mode[0], hit_a, hit_b) ? '0 : s16;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/twin_byte_timer.sv
module twin_byte_timer
    import tmr_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_wide,
    input  logic [AW-1:0]       bus_addr,
    input  logic [PAIR_W-1:0]   bus_wdata,
    output logic [PAIR_W-1:0]   bus_rdata,
    output logic [NCH-1:0]      irq_cmp_a,
    output logic [NCH-1:0]      irq_cmp_b,
    output logic [NCH-1:0]      irq_wrap
);
    localparam int HI_W = BYTE_W - CTRL_LSB;
    localparam logic [NCH-1:0][HI_W-1:0] STAT_RST = {5'h02, 5'h00};

    logic [NCH-1:0][HI_W-1:0]   ctrl_q;
    logic [NCH-1:0][HI_W-1:0]   stat_q;
    logic [NCH-1:0][BYTE_W-1:0] cmpa_q;
    logic [NCH-1:0][BYTE_W-1:0] cmpb_q;
    logic [NCH-1:0][BYTE_W-1:0] cnt_q;
    logic [NCH-1:0][CLKC_W-1:0] clkc_q;

    reg_sel_e                   rsel;
    logic                       lane;
    logic                       wide_ok;
    logic [NCH-1:0]             wr_en;
    logic [NCH-1:0]             cnt_wr;
    logic [NCH-1:0][BYTE_W-1:0] wd;
    logic [NCH-1:0][BYTE_W-1:0] rd_b;

    pair_mode_e                 pair_mode;
    logic [NCH-1:0]             tick;
    logic [NCH-1:0]             adv;
    logic [NCH-1:0][BYTE_W-1:0] nxt;
    logic [NCH-1:0]             ev_a, ev_b, ev_o;
    chan_view_t [NCH-1:0]       view;
    logic [NCH-1:0][1:0]        clr_mode;
    logic [NCH-1:0][2:0]        rate;

    // access decode
    assign rsel    = reg_sel_e'(bus_addr[3:1]);
    assign lane    = bus_addr[0];
    assign wide_ok = bus_wide && !lane;
    assign wr_en[0] = bus_wr && (wide_ok || (!bus_wide && !lane));
    assign wr_en[1] = bus_wr && (wide_ok || (!bus_wide &&  lane));
    assign wd[0]   = bus_wide ? bus_wdata[PAIR_W-1:BYTE_W] : bus_wdata[BYTE_W-1:0];
    assign wd[1]   = bus_wdata[BYTE_W-1:0];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign cnt_wr[g]        = wr_en[g] && (rsel == REG_CNT);
        assign view[g].cmpa     = cmpa_q[g];
        assign view[g].cmpb     = cmpb_q[g];
        assign view[g].cnt      = cnt_q[g];
        assign view[g].src      = clkc_q[g][4:3];
        assign clr_mode[g]      = ctrl_q[g][1:0];
        assign rate[g]          = clkc_q[g][2:0];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctrl_q[g] <= '0;
                stat_q[g] <= STAT_RST[g];
                cmpa_q[g] <= '1;
                cmpb_q[g] <= '1;
                cnt_q[g]  <= '0;
                clkc_q[g] <= '0;
            end else begin
                if (wr_en[g]) begin
                    unique case (rsel)
                        REG_CTRL: ctrl_q[g] <= wd[g][BYTE_W-1:CTRL_LSB];
                        REG_STAT: stat_q[g] <= wd[g][BYTE_W-1:CTRL_LSB];
                        REG_CMPA: cmpa_q[g] <= wd[g];
                        REG_CMPB: cmpb_q[g] <= wd[g];
                        REG_CLKC: clkc_q[g] <= wd[g][CLKC_W-1:0];
                        default:  ;
                    endcase
                end
                if (cnt_wr[g])   cnt_q[g] <= wd[g];
                else if (adv[g]) cnt_q[g] <= nxt[g];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                irq_cmp_a[g] <= 1'b0;
                irq_cmp_b[g] <= 1'b0;
                irq_wrap[g]  <= 1'b0;
            end else begin
                irq_cmp_a[g] <= ev_a[g] && ctrl_q[g][IE_A_BIT-CTRL_LSB];
                irq_cmp_b[g] <= ev_b[g] && ctrl_q[g][IE_B_BIT-CTRL_LSB];
                irq_wrap[g]  <= ev_o[g] && ctrl_q[g][IE_O_BIT-CTRL_LSB];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            unique case (rsel)
                REG_CTRL: rd_b[i] = {ctrl_q[i], 3'b000};
                REG_STAT: rd_b[i] = {stat_q[i], 3'b000};
                REG_CMPA: rd_b[i] = cmpa_q[i];
                REG_CMPB: rd_b[i] = cmpb_q[i];
                REG_CNT:  rd_b[i] = cnt_q[i];
                REG_CLKC: rd_b[i] = {3'b000, clkc_q[i]};
                default:  rd_b[i] = '0;
            endcase
        end
        if (bus_wide) bus_rdata = lane ? '0 : {rd_b[0], rd_b[1]};
        else          bus_rdata = {{BYTE_W{1'b0}}, rd_b[lane]};
    end

    tmr_prescaler #(.CHANNELS(NCH), .PW(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .rate  (rate),
        .tick  (tick)
    );

    tmr_count_core u_core (
        .ch       (view),
        .clr_mode (clr_mode),
        .tick     (tick),
        .cnt_wr   (cnt_wr),
        .mode     (pair_mode),
        .adv      (adv),
        .nxt      (nxt),
        .ev_a     (ev_a),
        .ev_b     (ev_b),
        .ev_o     (ev_o)
    );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       casc,
    input logic       ie_a0,
    input logic [1:0] clr0,
    input logic [2:0] rate1,
    input logic [7:0] cnt0,
    input logic [7:0] cnt1,
    input logic [1:0] irq_cmp_a,
    input logic [1:0] irq_cmp_b,
    input logic [1:0] irq_wrap
);
    // R11: channel 1 lines stay silent while chained
    p_chain_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        casc |=> (!irq_cmp_a[1] && !irq_cmp_b[1] && !irq_wrap[1]));

    // R5: a stopped rate holds channel 1's counter
    p_stop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rate1 == 3'd0 && !bus_wr) |=> $stable(cnt1));

    // R9: disabled compare A never pulses on channel 0
    p_gate_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_a0 |=> !irq_cmp_a[0]);

    // R6: channel 1 overflow pulse only after the counter sat at 0xFF
    p_wrap_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wrap[1] |-> ($past(cnt1) == 8'hFF));

    // R8: a compare A pulse under clear-on-A leaves channel 0 at zero
    p_clear_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_cmp_a[0] && $past(clr0) == 2'b01) |-> (cnt0 == 8'h00));
endmodule

bind twin_byte_timer tmr_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .casc      (pair_mode),
    .ie_a0     (ctrl_q[0][3]),
    .clr0      (ctrl_q[0][1:0]),
    .rate1     (clkc_q[1][2:0]),
    .cnt0      (cnt_q[0]),
    .cnt1      (cnt_q[1]),
    .irq_cmp_a (irq_cmp_a),
    .irq_cmp_b (irq_cmp_b),
    .irq_wrap  (irq_wrap)
);

// File: tb/twin_byte_timer_test.sv
module twin_byte_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_wide = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  irq_cmp_a, irq_cmp_b, irq_wrap;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    string       tag_q[$];
    logic [15:0] exp_q[$];
    logic [15:0] act_q[$];

    int pa[2], pb[2], po[2];

    always #5 clk = ~clk;

    twin_byte_timer #(.AW(4)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wide(bus_wide),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_cmp_a(irq_cmp_a), .irq_cmp_b(irq_cmp_b), .irq_wrap(irq_wrap)
    );

    // pulse monitor
    initial begin
        for (int i = 0; i < 2; i++) begin pa[i] = 0; pb[i] = 0; po[i] = 0; end
    end
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 2; i++) begin
                if (irq_cmp_a[i]) pa[i] = pa[i] + 1;
                if (irq_cmp_b[i]) pb[i] = pb[i] + 1;
                if (irq_wrap[i])  po[i] = po[i] + 1;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            string       t;
            logic [15:0] e, a;
            t = tag_q.pop_front();
            e = exp_q.pop_front();
            a = act_q.pop_front();
            checks++;
            if (a !== e) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", t, a, e);
            end
        end
    end

    task automatic expect_val(input string t, input logic [15:0] e, input logic [15:0] a);
        tag_q.push_back(t);
        exp_q.push_back(e);
        act_q.push_back(a);
    endtask

    task automatic bwrite(input logic [3:0] a, input logic w, input logic [15:0] d);
        bus_addr = a; bus_wide = w; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [3:0] a, input logic w, output logic [15:0] v);
        bus_addr = a; bus_wide = w;
        #1;
        v = bus_rdata;
    endtask

    // k counts: start, wait, stop, settle
    task automatic run(input logic [3:0] a, input logic w, input logic [15:0] on,
                       input logic [15:0] off, input int k);
        bwrite(a, w, on);
        repeat (k - 1) @(negedge clk);
        bwrite(a, w, off);
        @(negedge clk);
    endtask

    task automatic chk_rd(input string t, input logic [3:0] a, input logic w, input logic [15:0] e);
        logic [15:0] v;
        bread(a, w, v);
        expect_val(t, e, v);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int s0, s1, s2, s3, s4, s5;
        logic [15:0] v0, v1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_rd("R1 cmpa pair", 4'h4, 1'b1, 16'hFFFF);
        chk_rd("R1 cmpb pair", 4'h6, 1'b1, 16'hFFFF);
        chk_rd("R1 stat ch0", 4'h2, 1'b0, 16'h0000);
        chk_rd("R1 stat ch1", 4'h3, 1'b0, 16'h0010);
        chk_rd("R1 cnt pair", 4'h8, 1'b1, 16'h0000);
        chk_rd("R1 ctrl pair", 4'h0, 1'b1, 16'h0000);
        chk_rd("R1 clkc pair", 4'hA, 1'b1, 16'h0000);

        // R4 / R2 masking and unmapped
        bwrite(4'h0, 1'b0, 16'h00FF);
        chk_rd("R4 ctrl low bits", 4'h0, 1'b0, 16'h00F8);
        bwrite(4'h3, 1'b0, 16'h0037);
        chk_rd("R4 stat low bits", 4'h3, 1'b0, 16'h0030);
        bwrite(4'hB, 1'b0, 16'h00E0);
        chk_rd("R2 clkc upper bits", 4'hB, 1'b0, 16'h0000);
        bwrite(4'hC, 1'b0, 16'h00AA);
        chk_rd("R2 unmapped read", 4'hC, 1'b0, 16'h0000);
        bwrite(4'h0, 1'b0, 16'h0000);

        // R3 halfword split and odd halfword ignored
        bwrite(4'h6, 1'b1, 16'h3C5A);
        chk_rd("R3 hw cmpb ch0", 4'h6, 1'b0, 16'h003C);
        chk_rd("R3 hw cmpb ch1", 4'h7, 1'b0, 16'h005A);
        bwrite(4'h5, 1'b1, 16'h1234);
        chk_rd("R3 odd hw write ignored", 4'h4, 1'b1, 16'hFFFF);
        chk_rd("R3 odd hw read zero", 4'h5, 1'b1, 16'h0000);
        bwrite(4'h6, 1'b1, 16'hFFFF);

        // R6 free run ch1 at divide 1
        run(4'hB, 1'b0, 16'h0009, 16'h0000, 10);
        chk_rd("R6 ch1 count 10", 4'h9, 1'b0, 16'h000A);

        // R6 / R9 overflow pulse, compare A disabled
        bwrite(4'h1, 1'b0, 16'h0020);
        bwrite(4'h9, 1'b0, 16'h00F0);
        s0 = po[1]; s1 = pa[1];
        run(4'hB, 1'b0, 16'h0009, 16'h0000, 20);
        chk_rd("R6 ch1 wrapped", 4'h9, 1'b0, 16'h0004);
        expect_val("R6 overflow pulses", 16'(po[1] - s0), 16'd1);
        expect_val("R9 disabled A silent", 16'(pa[1] - s1), 16'd0);
        bwrite(4'h1, 1'b0, 16'h0000);

        // R7 / R8 clear on A, ch0
        bwrite(4'h0, 1'b0, 16'h0048);
        bwrite(4'h4, 1'b0, 16'h0005);
        bwrite(4'h8, 1'b0, 16'h0000);
        s0 = pa[0];
        run(4'hA, 1'b0, 16'h0009, 16'h0000, 12);
        chk_rd("R8 clear on A count", 4'h8, 1'b0, 16'h0002);
        expect_val("R7 A pulses", 16'(pa[0] - s0), 16'd2);

        // R8 / R9 clear on B, A matches but disabled
        bwrite(4'h0, 1'b0, 16'h0090);
        bwrite(4'h4, 1'b0, 16'h0002);
        bwrite(4'h6, 1'b0, 16'h0003);
        bwrite(4'h8, 1'b0, 16'h0000);
        s0 = pa[0]; s1 = pb[0];
        run(4'hA, 1'b0, 16'h0009, 16'h0000, 7);
        chk_rd("R8 clear on B count", 4'h8, 1'b0, 16'h0001);
        expect_val("R9 B pulses", 16'(pb[0] - s1), 16'd2);
        expect_val("R9 A gated", 16'(pa[0] - s0), 16'd0);

        // R10 simultaneous A and B
        bwrite(4'h0, 1'b0, 16'h00C8);
        bwrite(4'h4, 1'b0, 16'h0004);
        bwrite(4'h6, 1'b0, 16'h0004);
        bwrite(4'h8, 1'b0, 16'h0000);
        s0 = pa[0]; s1 = pb[0];
        run(4'hA, 1'b0, 16'h0009, 16'h0000, 9);
        chk_rd("R10 single clear count", 4'h8, 1'b0, 16'h0001);
        expect_val("R10 A pulses", 16'(pa[0] - s0), 16'd2);
        expect_val("R10 B pulses", 16'(pb[0] - s1), 16'd2);

        // R5 stopped rate, other sources
        bwrite(4'h9, 1'b0, 16'h0011);
        run(4'hB, 1'b0, 16'h0008, 16'h0000, 20);
        chk_rd("R5 rate 000 holds", 4'h9, 1'b0, 16'h0011);
        run(4'hB, 1'b0, 16'h0011, 16'h0000, 20);
        chk_rd("R5 source 10 holds", 4'h9, 1'b0, 16'h0011);
        run(4'hB, 1'b0, 16'h0019, 16'h0000, 20);
        chk_rd("R5 source 11 on ch1 holds", 4'h9, 1'b0, 16'h0011);

        // R5 divide 8 and divide 32
        bwrite(4'hB, 1'b0, 16'h000B);
        bread(4'h9, 1'b0, v0);
        repeat (64) @(negedge clk);
        bread(4'h9, 1'b0, v1);
        expect_val("R5 divide 8 rate", 16'((v1 - v0) & 16'h00FF), 16'd8);
        bwrite(4'hB, 1'b0, 16'h000C);
        bread(4'h9, 1'b0, v0);
        repeat (64) @(negedge clk);
        bread(4'h9, 1'b0, v1);
        expect_val("R5 divide 32 rate", 16'((v1 - v0) & 16'h00FF), 16'd2);
        bwrite(4'hB, 1'b0, 16'h0000);

        // R12 write priority over counting
        bwrite(4'hB, 1'b0, 16'h0009);
        bwrite(4'h9, 1'b0, 16'h0050);
        bwrite(4'hB, 1'b0, 16'h0000);
        @(negedge clk);
        chk_rd("R12 write wins", 4'h9, 1'b0, 16'h0051);

        // R11 cascade carry
        bwrite(4'h0, 1'b1, 16'h0000);
        bwrite(4'h6, 1'b1, 16'hFFFF);
        bwrite(4'h4, 1'b1, 16'hFFFF);
        bwrite(4'h8, 1'b1, 16'h00FD);
        run(4'hA, 1'b1, 16'h1809, 16'h0000, 5);
        chk_rd("R11 carry into high byte", 4'h8, 1'b1, 16'h0102);

        // R11 16-bit compare with clear, ch1 silent
        bwrite(4'h0, 1'b1, 16'h4840);
        bwrite(4'h4, 1'b1, 16'h0104);
        bwrite(4'h8, 1'b1, 16'h00FE);
        s0 = pa[0]; s1 = pa[1];
        run(4'hA, 1'b1, 16'h1809, 16'h0000, 10);
        chk_rd("R11 16-bit clear count", 4'h8, 1'b1, 16'h0004);
        expect_val("R11 ch0 A pulses", 16'(pa[0] - s0), 16'd1);
        expect_val("R11 ch1 A silent", 16'(pa[1] - s1), 16'd0);

        // R11 16-bit overflow
        bwrite(4'h0, 1'b1, 16'h2020);
        bwrite(4'h4, 1'b1, 16'hFFFF);
        bwrite(4'h8, 1'b1, 16'hFFFE);
        s2 = po[0]; s3 = po[1]; s4 = pb[0]; s5 = pb[1];
        run(4'hA, 1'b1, 16'h1809, 16'h0000, 4);
        chk_rd("R11 wrap count", 4'h8, 1'b1, 16'h0002);
        expect_val("R11 ch0 overflow pulses", 16'(po[0] - s2), 16'd1);
        expect_val("R11 ch1 overflow silent", 16'(po[1] - s3), 16'd0);
        expect_val("R11 B none", 16'((pb[0] - s4) + (pb[1] - s5)), 16'd0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule